// File: doc/BRIEF.md
# Serial Flash Command Gate and Write Protection

This block decides, for a serial NOR flash slave holding two stacked dies, whether each decoded command takes effect. The serial front end sends one event per command when chip select rises: the opcode, which die was selected, a block index, a small status payload, and a flag saying whether the command ended on a whole byte. The block samples that event together with the write-protect pin level, the quad-mode flag and the array's busy flag. One cycle later it issues a single accept or reject pulse and updates the protection state of the selected die.

Each die has its own state: a write-enable latch, four block-protect bits, a status-write-disable bit, a deep power-down flag, a one-time individual-protect mode select and one lock bit per block. A small state machine has two states. `ST_STANDBY` waits for `cmd_valid`; the transition "capture" stores the event and moves to `ST_DECIDE`. `ST_DECIDE` evaluates the command, commits the state of the die and pulses the verdict. The transition "retire" then returns to `ST_STANDBY`. An event offered while in `ST_DECIDE` is not captured, so the front end spaces commands at least two cycles apart.

Opcodes on `cmd_op`: 0 read, 1 write enable, 2 write disable, 3 write status, 4 program, 5 erase block, 6 chip erase, 7 lock block, 8 unlock block, 9 lock all, 10 unlock all, 11 enter power-down, 12 leave power-down, 13 read signature, 14 set individual-protect mode, 15 no operation. The write class is 3, 4, 5, 6, 7, 8, 9, 10 and 14.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: A command with `cmd_aligned`=0 is rejected and changes no state.
- R2: A write-class command is rejected with no state change while the write-enable latch of its die is 0. The latch is set only by an accepted opcode 1.
- R3: After reset all state of both dies is 0. An accepted opcode 2, 3, 4, 5, 6, 7, 8, 9, 10 or 14 leaves the latch at 0.
- R4: While a die is powered down, only opcodes 12 and 13 are accepted on it and all other opcodes are rejected with no state change. Opcode 11 enters power-down and opcode 12 leaves it.
- R5: With the mode select at 0, program or erase of block b is rejected when b + bp >= NBLK. Chip erase is rejected when bp is not 0.
- R6: A program or erase rejected by protection clears the write-enable latch.
- R7: Opcode 3 loads bp from `cmd_data[3:0]` and the disable bit from `cmd_data[4]`. It is rejected with no state change when `wp_n`=0, the disable bit is 1 and `quad_mode`=0. With `quad_mode`=1 the pin has no effect.
- R8: Opcode 14 sets the mode select, and nothing but reset clears it. While it is 1, bp is ignored: program or erase of a locked block is rejected, and chip erase is rejected if any lock bit is set. Lock opcodes 7 to 10 are rejected while it is 0.
- R9: Opcode 7 sets and opcode 8 clears the lock bit of `cmd_blk`. Opcode 9 sets all lock bits and opcode 10 clears them all.
- R10: A command affects only the die named by `cmd_die`.
- R11: A write-class command sampled with `busy`=1 is rejected with no state change.
- R12: Every command gives exactly one single-cycle pulse, on `accept` or on `reject`, visible in the second cycle after the `cmd_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all state |
| cmd_valid | input | 1 | One-cycle command event at chip-select rise |
| cmd_op | input | 4 | Opcode |
| cmd_die | input | DIEW | Index of the die whose chip select was active |
| cmd_blk | input | BLKW | Block index for program, erase, lock and unlock |
| cmd_data | input | 5 | Status payload: [3:0] protect bits, [4] disable bit |
| cmd_aligned | input | 1 | Command ended on a byte boundary |
| wp_n | input | 1 | Write-protect pin level |
| quad_mode | input | 1 | Data pins are in four-wire mode |
| busy | input | 1 | Array operation in progress |
| accept | output | 1 | Command accepted pulse |
| reject | output | 1 | Command rejected pulse |
| wel_o | output | NDIE | Write-enable latch per die |
| srwd_o | output | NDIE | Status-write-disable bit per die |
| dpd_o | output | NDIE | Power-down flag per die |
| ipm_o | output | NDIE | Individual-protect mode select per die |
| bp_o | output | 4*NDIE | Protect bits, die d at [4d+3:4d] |
| lock_o | output | NBLK*NDIE | Lock bits, die d at [NBLK*d+NBLK-1:NBLK*d] |

## Verification
The directed phase first sends each write-class opcode with the latch both clear and set, which separates gating from effect. It then walks the boundary block at bp=4 (blocks 11 and 12), which exposes an off-by-one in the region compare. The pin-protect case runs with the quad flag both low and high, and a second die runs between first-die commands so that leakage between dies shows up. A long pseudo-random phase mixes misalignment, busy, power-down and mode-select sequences, and the state of both dies is compared with a behavioural model on every clock.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    localparam int BPW = 4;

    typedef enum logic [3:0] {
        OP_READ     = 4'd0,
        OP_WREN     = 4'd1,
        OP_WRDI     = 4'd2,
        OP_WRSTAT   = 4'd3,
        OP_PROG     = 4'd4,
        OP_ERASE    = 4'd5,
        OP_CHIPER   = 4'd6,
        OP_LOCK     = 4'd7,
        OP_UNLOCK   = 4'd8,
        OP_GLOCK    = 4'd9,
        OP_GUNLOCK  = 4'd10,
        OP_PDOWN    = 4'd11,
        OP_PUP      = 4'd12,
        OP_SIG      = 4'd13,
        OP_SETIPM   = 4'd14,
        OP_NOP      = 4'd15
    } op_e;

    typedef enum logic {
        ST_STANDBY = 1'b0,
        ST_DECIDE  = 1'b1
    } st_e;
endpackage

// File: rtl/wprot_cmd_class.sv
module wprot_cmd_class
    import wprot_pkg::*;
(
    input  op_e  op,
    output logic is_write,
    output logic pd_pass
);
    always_comb begin
        is_write = 1'b0;
        pd_pass  = 1'b0;
        unique case (op)
            OP_WRSTAT, OP_PROG, OP_ERASE, OP_CHIPER,
            OP_LOCK, OP_UNLOCK, OP_GLOCK, OP_GUNLOCK,
            OP_SETIPM:          is_write = 1'b1;
            OP_PUP, OP_SIG:     pd_pass  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/wprot_region.sv
module wprot_region
    import wprot_pkg::*;
#(
    parameter int NBLK = 16,
    localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic [BPW-1:0]  bp,
    input  logic            ipm,
    input  logic [NBLK-1:0] locks,
    input  logic [BLKW-1:0] blk,
    output logic            blk_hit,
    output logic            chip_hit
);
    always_comb begin
        if (ipm) begin
            blk_hit  = locks[blk];
            chip_hit = |locks;
        end else begin
            blk_hit  = (int'(blk) + int'(bp)) >= NBLK;
            chip_hit = |bp;
        end
    end
endmodule

// File: rtl/wprot_die_regs.sv
module wprot_die_regs
    import wprot_pkg::*;
#(
    parameter int NBLK = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic            d_wel,
    input  logic [BPW-1:0]  d_bp,
    input  logic            d_srwd,
    input  logic            d_dpd,
    input  logic            d_ipm,
    input  logic [NBLK-1:0] d_lock,
    output logic            q_wel,
    output logic [BPW-1:0]  q_bp,
    output logic            q_srwd,
    output logic            q_dpd,
    output logic            q_ipm,
    output logic [NBLK-1:0] q_lock
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_wel  <= 1'b0;
            q_bp   <= '0;
            q_srwd <= 1'b0;
            q_dpd  <= 1'b0;
            q_ipm  <= 1'b0;
            q_lock <= '0;
        end else if (upd) begin
            q_wel  <= d_wel;
            q_bp   <= d_bp;
            q_srwd <= d_srwd;
            q_dpd  <= d_dpd;
            q_ipm  <= d_ipm;
            q_lock <= d_lock;
        end
    end
endmodule

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int NDIE = 2,
    parameter int NBLK = 16,
    localparam int DIEW = (NDIE > 1) ? $clog2(NDIE) : 1,
    localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [3:0]           cmd_op,
    input  logic [DIEW-1:0]      cmd_die,
    input  logic [BLKW-1:0]      cmd_blk,
    input  logic [BPW:0]         cmd_data,
    input  logic                 cmd_aligned,
    input  logic                 wp_n,
    input  logic                 quad_mode,
    input  logic                 busy,
    output logic                 accept,
    output logic                 reject,
    output logic [NDIE-1:0]      wel_o,
    output logic [NDIE-1:0]      srwd_o,
    output logic [NDIE-1:0]      dpd_o,
    output logic [NDIE-1:0]      ipm_o,
    output logic [NDIE*BPW-1:0]  bp_o,
    output logic [NDIE*NBLK-1:0] lock_o
);
    st_e             st_q;
    op_e             op_q;
    logic [DIEW-1:0] die_q;
    logic [BLKW-1:0] blk_q;
    logic [BPW:0]    data_q;
    logic            aligned_q, busy_q, wp_q, quad_q;
    logic            acc_q, rej_q;

    logic            wel_q  [NDIE];
    logic [BPW-1:0]  bp_q   [NDIE];
    logic            srwd_q [NDIE];
    logic            dpd_q  [NDIE];
    logic            ipm_q  [NDIE];
    logic [NBLK-1:0] lock_q [NDIE];

    logic            cur_wel, cur_srwd, cur_dpd, cur_ipm;
    logic [BPW-1:0]  cur_bp;
    logic [NBLK-1:0] cur_lock;
    logic            n_wel, n_srwd, n_dpd, n_ipm;
    logic [BPW-1:0]  n_bp;
    logic [NBLK-1:0] n_lock;
    logic            v_acc, v_rej;
    logic            is_wr, pd_pass, blk_hit, chip_hit, pin_lock;

    // state register: capture and retire
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_STANDBY;
            op_q      <= OP_NOP;
            die_q     <= '0;
            blk_q     <= '0;
            data_q    <= '0;
            aligned_q <= 1'b0;
            busy_q    <= 1'b0;
            wp_q      <= 1'b1;
            quad_q    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_STANDBY: if (cmd_valid) begin
                    st_q      <= ST_DECIDE;
                    op_q      <= op_e'(cmd_op);
                    die_q     <= cmd_die;
                    blk_q     <= cmd_blk;
                    data_q    <= cmd_data;
                    aligned_q <= cmd_aligned;
                    busy_q    <= busy;
                    wp_q      <= wp_n;
                    quad_q    <= quad_mode;
                end
                ST_DECIDE: st_q <= ST_STANDBY;
                default:   st_q <= ST_STANDBY;
            endcase
        end
    end

    // output register: verdict pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            acc_q <= (st_q == ST_DECIDE) && v_acc;
            rej_q <= (st_q == ST_DECIDE) && v_rej;
        end
    end

    assign accept = acc_q;
    assign reject = rej_q;

    assign cur_wel  = wel_q[die_q];
    assign cur_bp   = bp_q[die_q];
    assign cur_srwd = srwd_q[die_q];
    assign cur_dpd  = dpd_q[die_q];
    assign cur_ipm  = ipm_q[die_q];
    assign cur_lock = lock_q[die_q];
    assign pin_lock = !wp_q && cur_srwd && !quad_q;

    wprot_cmd_class u_class (
        .op       (op_q),
        .is_write (is_wr),
        .pd_pass  (pd_pass)
    );

    wprot_region #(.NBLK(NBLK)) u_region (
        .bp       (cur_bp),
        .ipm      (cur_ipm),
        .locks    (cur_lock),
        .blk      (blk_q),
        .blk_hit  (blk_hit),
        .chip_hit (chip_hit)
    );

    // command evaluation in ST_DECIDE
    always_comb begin
        n_wel  = cur_wel;
        n_bp   = cur_bp;
        n_srwd = cur_srwd;
        n_dpd  = cur_dpd;
        n_ipm  = cur_ipm;
        n_lock = cur_lock;
        v_acc  = 1'b0;
        v_rej  = 1'b0;
        if (!aligned_q) begin
            v_rej = 1'b1;
        end else if (cur_dpd) begin
            if (pd_pass) begin
                v_acc = 1'b1;
                if (op_q == OP_PUP) n_dpd = 1'b0;
            end else begin
                v_rej = 1'b1;
            end
        end else if (is_wr && (busy_q || !cur_wel)) begin
            v_rej = 1'b1;
        end else begin
            unique case (op_q)
                OP_WREN: begin
                    n_wel = 1'b1;
                    v_acc = 1'b1;
                end
                OP_WRDI: begin
                    n_wel = 1'b0;
                    v_acc = 1'b1;
                end
                OP_WRSTAT: begin
                    if (pin_lock) begin
                        v_rej = 1'b1;
                    end else begin
                        n_bp   = data_q[BPW-1:0];
                        n_srwd = data_q[BPW];
                        n_wel  = 1'b0;
                        v_acc  = 1'b1;
                    end
                end
                OP_PROG, OP_ERASE: begin
                    n_wel = 1'b0;
                    v_rej = blk_hit;
                    v_acc = !blk_hit;
                end
                OP_CHIPER: begin
                    n_wel = 1'b0;
                    v_rej = chip_hit;
                    v_acc = !chip_hit;
                end
                OP_LOCK, OP_UNLOCK, OP_GLOCK, OP_GUNLOCK: begin
                    if (!cur_ipm) begin
                        v_rej = 1'b1;
                    end else begin
                        n_wel = 1'b0;
                        v_acc = 1'b1;
                        if (op_q == OP_LOCK)    n_lock[blk_q] = 1'b1;
                        if (op_q == OP_UNLOCK)  n_lock[blk_q] = 1'b0;
                        if (op_q == OP_GLOCK)   n_lock = '1;
                        if (op_q == OP_GUNLOCK) n_lock = '0;
                    end
                end
                OP_SETIPM: begin
                    n_ipm = 1'b1;
                    n_wel = 1'b0;
                    v_acc = 1'b1;
                end
                OP_PDOWN: begin
                    n_dpd = 1'b1;
                    v_acc = 1'b1;
                end
                default: v_acc = 1'b1;
            endcase
        end
    end

    for (genvar d = 0; d < NDIE; d++) begin : g_die
        logic upd;
        assign upd = (st_q == ST_DECIDE) && (int'(die_q) == d);

        wprot_die_regs #(.NBLK(NBLK)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd),
            .d_wel  (n_wel),
            .d_bp   (n_bp),
            .d_srwd (n_srwd),
            .d_dpd  (n_dpd),
            .d_ipm  (n_ipm),
            .d_lock (n_lock),
            .q_wel  (wel_q[d]),
            .q_bp   (bp_q[d]),
            .q_srwd (srwd_q[d]),
            .q_dpd  (dpd_q[d]),
            .q_ipm  (ipm_q[d]),
            .q_lock (lock_q[d])
        );

        assign wel_o[d]                 = wel_q[d];
        assign srwd_o[d]                = srwd_q[d];
        assign dpd_o[d]                 = dpd_q[d];
        assign ipm_o[d]                 = ipm_q[d];
        assign bp_o[d*BPW +: BPW]       = bp_q[d];
        assign lock_o[d*NBLK +: NBLK]   = lock_q[d];

        assert_wel_set_by_wren_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wel_q[d]) |-> $past(st_q == ST_DECIDE && op_q == OP_WREN && int'(die_q) == d));

        assert_ipm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ipm_q[d] |=> ipm_q[d]);

        assert_die_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_DECIDE && int'(die_q) != d) |=>
                ($stable(wel_q[d]) && $stable(bp_q[d]) && $stable(lock_q[d]) && $stable(dpd_q[d])));
    end

    assert_misaligned_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE && !aligned_q) |=> reject);

    assert_pdown_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE && cur_dpd && !pd_pass) |=> reject);

    assert_busy_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE && busy_q && is_wr) |=> reject);

    assert_one_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, reject}));

    assert_verdict_single_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |=> !(accept || reject));
endmodule

// File: tb/flash_wprot_ctrl_test.sv
module flash_wprot_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NDIE = 2;
    localparam int NBLK = 16;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd15;
    logic [0:0]  cmd_die = 1'b0;
    logic [3:0]  cmd_blk = 4'd0;
    logic [4:0]  cmd_data = 5'd0;
    logic        cmd_aligned = 1'b1;
    logic        wp_n = 1'b1;
    logic        quad_mode = 1'b0;
    logic        busy = 1'b0;
    logic        accept, reject;
    logic [1:0]  wel_o, srwd_o, dpd_o, ipm_o;
    logic [7:0]  bp_o;
    logic [31:0] lock_o;

    flash_wprot_ctrl #(.NDIE(NDIE), .NBLK(NBLK)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_die(cmd_die), .cmd_blk(cmd_blk), .cmd_data(cmd_data),
        .cmd_aligned(cmd_aligned), .wp_n(wp_n), .quad_mode(quad_mode),
        .busy(busy), .accept(accept), .reject(reject), .wel_o(wel_o),
        .srwd_o(srwd_o), .dpd_o(dpd_o), .ipm_o(ipm_o), .bp_o(bp_o),
        .lock_o(lock_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_wel [NDIE];
    int m_bp  [NDIE];
    int m_srwd[NDIE];
    int m_dpd [NDIE];
    int m_ipm [NDIE];
    logic [NBLK-1:0] m_lock[NDIE];
    int exp_acc = 0;
    int exp_rej = 0;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string req = "R12";

    task automatic chk(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cycles++;
        chk("accept", int'(accept), exp_acc);
        chk("reject", int'(reject), exp_rej);
        for (int d = 0; d < NDIE; d++) begin
            chk("wel",  int'(wel_o[d]),  m_wel[d]);
            chk("srwd", int'(srwd_o[d]), m_srwd[d]);
            chk("dpd",  int'(dpd_o[d]),  m_dpd[d]);
            chk("ipm",  int'(ipm_o[d]),  m_ipm[d]);
            chk("bp",   int'(bp_o[d*4 +: 4]), m_bp[d]);
            chk("lock", int'(lock_o[d*NBLK +: NBLK]), int'(m_lock[d]));
        end
    endtask

    task automatic model(input int op, input int die, input int blk, input int data,
                         input bit al, input bit bz, input bit wp, input bit qd);
        bit wr, prot;
        wr = (op >= 3 && op <= 10) || op == 14;
        exp_acc = 0;
        exp_rej = 0;
        if (!al) exp_rej = 1;
        else if (m_dpd[die] != 0) begin
            if (op == 12 || op == 13) begin
                exp_acc = 1;
                if (op == 12) m_dpd[die] = 0;
            end else exp_rej = 1;
        end else if (wr && (bz || m_wel[die] == 0)) exp_rej = 1;
        else begin
            case (op)
                1: begin m_wel[die] = 1; exp_acc = 1; end
                2: begin m_wel[die] = 0; exp_acc = 1; end
                3: if (!wp && m_srwd[die] != 0 && !qd) exp_rej = 1;
                   else begin
                       m_bp[die] = data % 16; m_srwd[die] = data / 16;
                       m_wel[die] = 0; exp_acc = 1;
                   end
                4, 5, 6: begin
                    if (op == 6) prot = (m_ipm[die] != 0) ? (m_lock[die] != 0) : (m_bp[die] != 0);
                    else prot = (m_ipm[die] != 0) ? m_lock[die][blk] : (blk + m_bp[die] >= NBLK);
                    m_wel[die] = 0;
                    if (prot) exp_rej = 1; else exp_acc = 1;
                end
                7, 8, 9, 10: if (m_ipm[die] == 0) exp_rej = 1;
                   else begin
                       if (op == 7) m_lock[die][blk] = 1'b1;
                       if (op == 8) m_lock[die][blk] = 1'b0;
                       if (op == 9) m_lock[die] = '1;
                       if (op == 10) m_lock[die] = '0;
                       m_wel[die] = 0; exp_acc = 1;
                   end
                14: begin m_ipm[die] = 1; m_wel[die] = 0; exp_acc = 1; end
                11: begin m_dpd[die] = 1; exp_acc = 1; end
                default: exp_acc = 1;
            endcase
        end
    endtask

    task automatic issue(input int op, input int die = 0, input int blk = 0, input int data = 0,
                         input bit al = 1, input bit bz = 0, input bit wp = 1, input bit qd = 0);
        cmd_valid = 1'b1;
        cmd_op = op[3:0]; cmd_die = die[0:0]; cmd_blk = blk[3:0]; cmd_data = data[4:0];
        cmd_aligned = al; busy = bz; wp_n = wp; quad_mode = qd;
        tick();
        cmd_valid = 1'b0;
        model(op, die, blk, data, al, bz, wp, qd);
        tick();
        exp_acc = 0;
        exp_rej = 0;
        tick();
    endtask

    initial begin
        for (int d = 0; d < NDIE; d++) begin
            m_wel[d] = 0; m_bp[d] = 0; m_srwd[d] = 0; m_dpd[d] = 0; m_ipm[d] = 0; m_lock[d] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = "R12"; tick();                          // reset state, R3 too
        req = "R2";  issue(4, 0, 0);                  // program without latch
                     issue(1);                        // latch set
        req = "R3";  issue(2);                        // write disable
                     issue(1); issue(3, 0, 0, 0);     // status write clears latch
                     issue(1); issue(4, 0, 0);
                     issue(1); issue(5, 0, 3);
                     issue(1); issue(6);
        req = "R1";  issue(1, 0, 0, 0, 0);            // misaligned enable ignored
                     issue(1); issue(2, 0, 0, 0, 0);  // misaligned disable ignored
        req = "R5";  issue(1); issue(3, 0, 0, 4);     // bp=4 protects blocks 12..15
                     issue(1); issue(4, 0, 11);       // boundary just outside
        req = "R6";  issue(1); issue(4, 0, 12);       // protected: rejected, latch cleared
        req = "R5";  issue(1); issue(6);              // chip erase blocked
        req = "R7";  issue(1); issue(3, 0, 0, 5'h14); // srwd=1, bp=4
                     issue(1); issue(3, 0, 0, 0, 1, 0, 0, 0);  // pin blocks
                     issue(3, 0, 0, 0, 1, 0, 0, 1);            // quad mode bypass
        req = "R11"; issue(1); issue(4, 0, 0, 0, 1, 1);
                     issue(2);
        req = "R10"; issue(1, 1); issue(3, 1, 0, 2);
                     issue(1, 1); issue(4, 1, 14);
        req = "R4";  issue(11); issue(1); issue(13); issue(12); issue(1);
        req = "R8";  issue(7, 0, 2);                  // lock without mode select
                     issue(1); issue(3, 0, 0, 15);
                     issue(1); issue(14);
                     issue(1); issue(4, 0, 5);        // bp ignored
        req = "R9";  issue(1); issue(7, 0, 3);
        req = "R8";  issue(1); issue(4, 0, 3);        // locked block
                     issue(1); issue(6);
        req = "R9";  issue(1); issue(9); issue(1); issue(8, 0, 7);
                     issue(1); issue(10);
        req = "R10"; issue(1, 1); issue(7, 1, 1);
        req = "R12";
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = ($urandom_range(0, 99) < 35) ? 1 : $urandom_range(0, 15);
            if (op == 11 && $urandom_range(0, 3) != 0) op = 12;
            issue(op, $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 31),
                  $urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0,
                  $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule